// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between a set of interrupt sources and a small CPU core. Every source supplies a flag bit and a local enable bit. A source counts as pending only when both bits are 1. When at least one source is pending and the CPU's global mask bit is clear, the controller waits for the next instruction boundary. At that boundary it accepts the interrupt, latches the index of the winning source and raises a one-cycle taken pulse. The CPU answers that pulse by setting its global mask bit.

Saving the CPU registers is handed to an outside stacking engine. That engine pushes the program counter low byte, then the high byte, then X, then A, then the condition codes. The controller holds a stacking request until a done strobe returns. It then reads the two bytes of the selected source's service address from a vector table, most significant byte first. It presents the assembled 16-bit vector for exactly one cycle.

Each source owns two consecutive bytes in the table, and a higher index means a higher priority. A parameter sets the table base. A second parameter sets whether slots grow upward or downward in memory.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source is pending only when its `src_flag` bit and its `src_en` bit are both 1. A flag whose enable is 0 never leads to `take_pulse`.
- R2: No interrupt is accepted while `gmask` is 1. `take_pulse` is the request to the CPU to set `gmask` to 1.
- R3: Acceptance happens only on a clock edge where `insn_end` is 1 while the controller is waiting. `take_pulse` is high for exactly the one cycle after that edge, together with `stack_req`.
- R4: `stack_req` stays high until a cycle with `stack_done` = 1. No vector read (`rd_en`) starts before that cycle.
- R5: When several sources are pending at acceptance, the one with the highest index is selected and shown on `src_idx`.
- R6: The high byte is read first, from the slot address. The low byte is read in the following cycle, from the slot address plus 1. `vec_out` holds high byte in bits 15:8 and low byte in bits 7:0. Read data is sampled in the same cycle as its `rd_en` strobe.
- R7: With default parameters (`VEC_BASE` = 0xFFC0, `ASCEND` = 1), the slot address of source i is 0xFFC0 + 2*i. With `ASCEND` = 0 it is `VEC_BASE` - 2*i.
- R8: `vec_valid` is high for exactly one cycle, the cycle right after the low-byte read.
- R9: The source index is latched at acceptance. Flag or enable changes after that do not alter `src_idx`, the read addresses or the vector returned.
- R10: If the pending condition disappears, or `gmask` becomes 1, before the instruction boundary, the controller returns to idle without taking the interrupt.
- R11: During and right after reset, `take_pulse`, `stack_req`, `rd_en` and `vec_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | N_SRC | Interrupt flag per source |
| src_en | input | N_SRC | Local enable per source |
| gmask | input | 1 | CPU global interrupt mask (1 = masked) |
| insn_end | input | 1 | Strobe: current instruction completes this cycle |
| stack_done | input | 1 | Stacking engine finished saving registers |
| rd_data | input | 8 | Vector table byte, valid in the strobe cycle |
| take_pulse | output | 1 | One-cycle interrupt-taken pulse (CPU sets mask) |
| stack_req | output | 1 | Request to save CPU registers |
| rd_en | output | 1 | Vector table read strobe |
| rd_addr | output | ADDR_W | Vector table byte address |
| vec_valid | output | 1 | Assembled vector valid this cycle |
| vec_out | output | 16 | Service-routine address |
| src_idx | output | IDX_W | Index of the accepted source |

## Verification
The assertions check these rules on every cycle:
- no acceptance while masked, and none away from an instruction boundary;
- a single-cycle taken pulse that comes with the stacking request;
- no read before the stacking done strobe;
- the low-byte address following the high-byte address by one;
- a single-cycle valid strobe;
- the source index held steady through the fetch.

Only the bench's scenarios can show three further behaviours. The first is that the highest pending index is the one chosen. The second is that the assembled vector matches the table contents at the mapped slot. The third is that a disabled flag, a withdrawn request or a raised mask before the boundary leads to no service.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STACK,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_DONE
    } ivc_state_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_word_t;

    // Byte offset of a source's slot from the table base.
    function automatic int unsigned slot_offset(input int unsigned idx);
        return idx * 2;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Ascending scan: a later (higher) index overrides earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
    import irq_vec_pkg::*;
#(
    parameter int              IDX_W    = 3,
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0,
    parameter bit              ASCEND   = 1'b1
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              sel_lo,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] slot;

    assign offs = ADDR_W'(slot_offset(32'(idx)));

    generate
        if (ASCEND) begin : g_up
            assign slot = VEC_BASE + offs;
        end else begin : g_down
            assign slot = VEC_BASE - offs;
        end
    endgenerate

    assign addr = sel_lo ? slot + ADDR_W'(1) : slot;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int                N_SRC    = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFC0,
    parameter bit                ASCEND   = 1'b1,
    localparam int               IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_flag,
    input  logic [N_SRC-1:0]  src_en,
    input  logic              gmask,
    input  logic              insn_end,
    input  logic              stack_done,
    input  logic [7:0]        rd_data,
    output logic              take_pulse,
    output logic              stack_req,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              vec_valid,
    output logic [15:0]       vec_out,
    output logic [IDX_W-1:0]  src_idx
);
    ivc_state_e       state, nxt;
    logic             accept;
    logic             any_pend;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] idx_q;
    logic             take_q;
    vec_word_t        vec_q;

    irq_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .pend (src_flag & src_en),
        .any  (any_pend),
        .idx  (pick_idx)
    );

    irq_vec_addr #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .ASCEND(ASCEND)
    ) u_addr (
        .idx    (idx_q),
        .sel_lo (state == ST_FETCH_LO),
        .addr   (rd_addr)
    );

    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            ST_IDLE:     if (any_pend && !gmask) nxt = ST_WAIT;
            ST_WAIT: begin
                if (!any_pend || gmask) begin
                    nxt = ST_IDLE;
                end else if (insn_end) begin
                    nxt    = ST_STACK;
                    accept = 1'b1;
                end
            end
            ST_STACK:    if (stack_done) nxt = ST_FETCH_HI;
            ST_FETCH_HI: nxt = ST_FETCH_LO;
            ST_FETCH_LO: nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            state  <= nxt;
            take_q <= accept;
            if (accept)                idx_q    <= pick_idx;
            if (state == ST_FETCH_HI)  vec_q.hi <= rd_data;
            if (state == ST_FETCH_LO)  vec_q.lo <= rd_data;
        end
    end

    assign take_pulse = take_q;
    assign stack_req  = (state == ST_STACK);
    assign rd_en      = (state == ST_FETCH_HI) || (state == ST_FETCH_LO);
    assign vec_valid  = (state == ST_DONE);
    assign vec_out    = vec_q;
    assign src_idx    = idx_q;

    // R2
    a_r2_no_take_masked: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> !$past(gmask));
    // R3
    a_r3_take_at_boundary: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> $past(insn_end));
    a_r3_take_with_stack: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> stack_req);
    a_r3_take_single: assert property (@(posedge clk) disable iff (rst)
        take_pulse |=> !take_pulse);
    // R4
    a_r4_read_after_stack: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> $past(stack_done) && $past(stack_req));
    // R6
    a_r6_low_follows_high: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> rd_addr == ADDR_W'($past(rd_addr) + ADDR_W'(1)));
    // R8
    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);
    a_r8_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(rd_en));
    // R9
    a_r9_idx_held: assert property (@(posedge clk) disable iff (rst)
        (rd_en || vec_valid) |-> $stable(src_idx));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [N-1:0] src_flag, src_en;
    logic        gmask, insn_end, stack_done;
    logic [7:0]  rd_data;
    logic        take_pulse, stack_req, rd_en, vec_valid;
    logic [15:0] rd_addr, vec_out;
    logic [2:0]  src_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mb(input logic [15:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic int exp_idx(input logic [N-1:0] p);
        for (int i = N - 1; i >= 0; i--) if (p[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] slot(input int i);
        return 16'hFFC0 + 16'(2 * i);
    endfunction

    assign rd_data = mb(rd_addr);

    irq_vector_ctrl u_dut (
        .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
        .gmask(gmask), .insn_end(insn_end), .stack_done(stack_done),
        .rd_data(rd_data), .take_pulse(take_pulse), .stack_req(stack_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .vec_valid(vec_valid),
        .vec_out(vec_out), .src_idx(src_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive a pending pattern, then expect no take for several cycles.
    task automatic expect_none(input logic [N-1:0] fl, input logic [N-1:0] en,
                               input logic gm, input string req);
        @(negedge clk);
        src_flag = fl; src_en = en; gmask = gm;
        repeat (3) @(negedge clk);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(!take_pulse && !stack_req, req, take_pulse, 0);
            @(negedge clk);
        end
    endtask

    task automatic service(input logic [N-1:0] fl, input logic [N-1:0] en,
                           input int pre, input int sd);
        int e;
        logic [15:0] a;
        @(negedge clk);
        src_flag = fl; src_en = en; gmask = 1'b0;
        insn_end = 1'b0; stack_done = 1'b0;
        e = exp_idx(fl & en);
        a = slot(e);
        for (int k = 0; k < pre; k++) begin
            @(negedge clk);
            chk(!take_pulse, "R3 no take before boundary", take_pulse, 0);
        end
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        chk(take_pulse, "R3 take pulse", take_pulse, 1);
        chk(stack_req, "R3 stack with take", stack_req, 1);
        chk(src_idx == e[2:0], "R5 highest index", src_idx, e);
        gmask = 1'b1;                 // CPU sets the mask on take
        src_flag = N'($urandom);      // R9: disturb sources during service
        src_en   = N'($urandom);
        for (int k = 0; k < sd; k++) begin
            chk(!rd_en && stack_req, "R4 wait stack_done", rd_en, 0);
            @(negedge clk);
            chk(!take_pulse, "R3 single pulse", take_pulse, 0);
        end
        stack_done = 1'b1;
        @(negedge clk);
        stack_done = 1'b0;
        chk(!take_pulse, "R3 single pulse", take_pulse, 0);
        chk(rd_en && rd_addr == a, "R7 high byte slot", rd_addr, a);
        @(negedge clk);
        chk(rd_en && rd_addr == a + 16'd1, "R6 low byte addr", rd_addr, a + 16'd1);
        @(negedge clk);
        chk(vec_valid && vec_out == {mb(a), mb(a + 16'd1)}, "R6 vector",
            vec_out, {mb(a), mb(a + 16'd1)});
        chk(src_idx == e[2:0], "R9 index held", src_idx, e);
        @(negedge clk);
        chk(!vec_valid && !rd_en, "R8 valid one cycle", vec_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; src_flag = '0; src_en = '0; gmask = 1'b1;
        insn_end = 1'b0; stack_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(!take_pulse && !stack_req && !rd_en && !vec_valid, "R11 in reset", take_pulse, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!take_pulse && !stack_req && !rd_en && !vec_valid, "R11 after reset", stack_req, 0);

        // Directed corners
        service(8'b0000_0001, 8'hFF, 2, 0);        // R7 lowest slot
        service(8'hFF, 8'hFF, 2, 3);               // R5 all pending -> 7
        service(8'b0101_0110, 8'b0001_1111, 4, 1); // R1/R5 enable mask -> 4
        expect_none(8'hFF, 8'h00, 1'b0, "R1 flags without enable");
        expect_none(8'h10, 8'h10, 1'b1, "R2 masked");

        // R10: pending withdrawn before boundary
        @(negedge clk);
        src_flag = 8'h08; src_en = 8'h08; gmask = 1'b0;
        repeat (2) @(negedge clk);
        src_en = 8'h00;
        @(negedge clk);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        src_en = 8'h08; gmask = 1'b1;
        chk(!take_pulse && !stack_req, "R10 withdrawn", take_pulse, 0);
        @(negedge clk);
        chk(!take_pulse, "R10 withdrawn later", take_pulse, 0);

        // R10: mask raised before boundary
        @(negedge clk);
        gmask = 1'b0;
        repeat (2) @(negedge clk);
        gmask = 1'b1;
        @(negedge clk);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        chk(!take_pulse && !stack_req, "R10 mask raised", take_pulse, 0);

        // Constrained random
        for (int t = 0; t < 40; t++) begin
            logic [N-1:0] f, e;
            int b;
            f = N'($urandom);
            e = N'($urandom);
            if ((f & e) == '0) begin
                b = $urandom_range(N - 1, 0);
                f[b] = 1'b1;
                e[b] = 1'b1;
            end
            service(f, e, $urandom_range(5, 2), $urandom_range(4, 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule